// File: doc/BRIEF.md
# Three-Wire Control Register Slave

This block is the device end of a three-wire serial control port: a mode line, a serial clock and a data line that the device drives only when it replies. While the mode line is low the controller sends an 8-bit device-select byte. Its upper six bits carry the device address and its lower two bits give the transfer type. While the mode line is high the controller sends the bytes that follow. A write names a register and supplies a 16-bit value in two bytes. A read takes two transactions. A write-type transaction whose register byte has its flag set arms a pending read. The next select byte, with type 11, then makes the device shift out three bytes: the requested register address with a validity flag, then the register's high and low data bytes.

All serial lines are brought into the system clock domain through synchronizers. Serial edges are found by comparing successive synchronized samples. The registers sit in a plain memory with a registered read port, so an FPGA can map them to block RAM. After reset the port stays deaf until it has seen one rising edge of the serial clock. That edge only enables the port and carries no data.

Top module: `tw_ctrl_slave`

## Requirements
- R1: After reset `ser_data_oe` is 0 and `ser_data_out` is 0. Register contents are not cleared by reset.
- R2: After reset, the first rising edge of `ser_clk` only enables the port and is not taken as a data bit. Any transfer that began before that edge is lost.
- R3: A write stores a register. The select byte has type 01 and a matching device address. The register byte has bit 7 = 0 and the register address in bits 6:0. The first data byte is the value's high byte and the second is its low byte. The register takes the value when the last bit of the second data byte arrives.
- R4: Each byte is sampled on rising `ser_clk` edges, bit 0 first and bit 7 last. In the select byte, bits 1:0 are the type and bits 7:2 are the device address.
- R5: A register byte with bit 7 = 1 arms a read of the register it names. A following select byte with a matching address and type 11 produces a 24-bit reply, bit 0 first. Reply bits 7:0 are {invalid flag, 7-bit register address}. Bits 15:8 are the data high byte and bits 23:16 are the data low byte.
- R6: Register addresses at or above NUM_REGS are invalid. They are echoed with bit 7 = 1 and read as zero data, and writes to them change nothing.
- R7: A select byte whose device address does not match makes the port ignore every byte until the next select phase. It neither writes nor drives.
- R8: `ser_data_oe` is 1 only during the 24 reply bits of an armed type-11 transaction. It falls after the 24th rising edge. A type-11 select with no armed read gives no drive.
- R9: An armed read lasts for exactly one select phase. Any other select byte that comes in between cancels it.
- R10: `ser_data_out` and the rise of `ser_data_oe` change only after a falling `ser_clk` edge. They stay stable across rising edges.
- R11: Bytes after the second data byte of a write are ignored and do not modify the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_mode | input | 1 | Mode line: low for the select byte, high for the following bytes |
| ser_clk | input | 1 | Serial clock, idles high |
| ser_data_in | input | 1 | Serial data from the controller |
| ser_data_out | output | 1 | Serial reply data |
| ser_data_oe | output | 1 | Output enable for the data-line driver |

## Verification
The assertions check on every cycle the rules that do not depend on data values. The driver may be on only in an armed read phase, with mode high, after the port is enabled. The reply bit and the driver enable may change only after a falling serial edge. The register memory is never written at an invalid address, and the port is silent after reset. Only the bench's scenarios can show the values that come back. These cover stored and returned data, byte and bit order, the echoed address and validity flag, and the discarded enable edge. They also cover rejection of foreign device addresses, cancellation of an armed read, and extra bytes being ignored.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_WRITE,
    PH_READ,
    PH_SKIP
  } phase_t;

  localparam int          BYTE_W     = 8;
  localparam int          REPLY_BITS = 3 * BYTE_W;
  localparam logic [1:0]  TYPE_WR    = 2'b01;
  localparam logic [1:0]  TYPE_RD    = 2'b11;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int              STAGES  = 2,
  parameter int              WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stg[g] <= RST_VAL;
      end else if (g == 0) begin
        stg[g] <= d;
      end else begin
        stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tw_reply_tx.sv
module tw_reply_tx #(
  parameter int NBITS = 24,
  parameter int IW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall_evt,
  input  logic             active,
  input  logic [IW-1:0]    bit_idx,
  input  logic [NBITS-1:0] reply,
  output logic             dout,
  output logic             oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= 1'b0;
      oe   <= 1'b0;
    end else if (!active) begin
      oe   <= 1'b0;
    end else if (fall_evt) begin
      oe   <= 1'b1;
      dout <= reply[bit_idx];
    end
  end
endmodule

// File: rtl/tw_ctrl_slave.sv
module tw_ctrl_slave
  import tw_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR    = 6'h2A,
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_mode,
  input  logic ser_clk,
  input  logic ser_data_in,
  output logic ser_data_out,
  output logic ser_data_oe
);
  localparam int         REG_W = 2 * BYTE_W;
  localparam int         AW    = $clog2(NUM_REGS);
  localparam logic [7:0] NREG8 = 8'(NUM_REGS);
  localparam int         IW    = $clog2(REPLY_BITS);

  // synchronized lines: {mode, clock, data}, idle level high for mode and clock
  logic mode_s, sclk_s, din_s;
  tw_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b110)) sync_i (
    .clk(clk), .rst(rst),
    .d({ser_mode, ser_clk, ser_data_in}),
    .q({mode_s, sclk_s, din_s})
  );

  logic sclk_q, mode_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b1;
      mode_q <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      mode_q <= mode_s;
    end
  end

  logic rise_evt, fall_evt, mode_fall, mode_rise;
  assign rise_evt  =  sclk_s & ~sclk_q;
  assign fall_evt  = ~sclk_s &  sclk_q;
  assign mode_fall = ~mode_s &  mode_q;
  assign mode_rise =  mode_s & ~mode_q;

  phase_t            phase;
  logic              enabled;
  logic [6:0]        sh;
  logic [2:0]        bit_cnt;
  logic [1:0]        byte_cnt;
  logic              rd_armed, wr_ok;
  logic [6:0]        rd_ptr, wr_ptr;
  logic [7:0]        hi_byte;
  logic [7:0]        new_byte;
  logic              byte_done, dev_match;

  assign new_byte  = {din_s, sh};
  assign byte_done = enabled && rise_evt && (bit_cnt == 3'd7);
  assign dev_match = (new_byte[7:2] == DEV_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      enabled  <= 1'b0;
      sh       <= '0;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      rd_armed <= 1'b0;
      wr_ok    <= 1'b0;
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      hi_byte  <= '0;
    end else begin
      if (rise_evt) begin
        enabled <= 1'b1;
      end
      if (enabled) begin
        if (mode_fall) begin
          phase    <= PH_ADDR;
          bit_cnt  <= '0;
          byte_cnt <= '0;
        end else if (mode_rise) begin
          bit_cnt  <= '0;
          byte_cnt <= '0;
          if (phase == PH_ADDR) begin
            phase <= PH_SKIP;
          end
        end else if (rise_evt) begin
          sh      <= new_byte[7:1];
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7 && byte_cnt != 2'd3) begin
            byte_cnt <= byte_cnt + 2'd1;
          end
        end
      end
      if (byte_done && !mode_fall && !mode_rise) begin
        unique case (phase)
          PH_ADDR: begin
            if (!mode_s) begin
              rd_armed <= 1'b0;
              wr_ok    <= 1'b0;
              if (dev_match && new_byte[1:0] == TYPE_WR) begin
                phase <= PH_WRITE;
              end else if (dev_match && new_byte[1:0] == TYPE_RD && rd_armed) begin
                phase <= PH_READ;
              end else begin
                phase <= PH_SKIP;
              end
            end
          end
          PH_WRITE: begin
            if (mode_s && byte_cnt == 2'd0) begin
              if (new_byte[7]) begin
                rd_armed <= 1'b1;
                rd_ptr   <= new_byte[6:0];
              end else begin
                wr_ok    <= 1'b1;
                wr_ptr   <= new_byte[6:0];
              end
            end else if (mode_s && byte_cnt == 2'd1) begin
              hi_byte <= new_byte;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // register bank
  logic              mem_we;
  logic [REG_W-1:0]  rdata;
  assign mem_we = byte_done && !mode_fall && !mode_rise && mode_s &&
                  (phase == PH_WRITE) && (byte_cnt == 2'd2) && wr_ok &&
                  ({1'b0, wr_ptr} < NREG8);

  tw_regfile #(.DEPTH(NUM_REGS), .WIDTH(REG_W), .AW(AW)) regs_i (
    .clk(clk),
    .we(mem_we),
    .waddr(wr_ptr[AW-1:0]),
    .wdata({hi_byte, new_byte}),
    .raddr(rd_ptr[AW-1:0]),
    .rdata(rdata)
  );

  // reply assembly: [7:0] echo, [15:8] high byte, [23:16] low byte
  logic                  rd_valid;
  logic [REG_W-1:0]      rd_word;
  logic [REPLY_BITS-1:0] reply;
  logic                  tx_active;
  logic [IW-1:0]         bit_idx;

  assign rd_valid  = ({1'b0, rd_ptr} < NREG8);
  assign rd_word   = rd_valid ? rdata : '0;
  assign reply     = {rd_word[7:0], rd_word[15:8], ~rd_valid, rd_ptr};
  assign tx_active = enabled && (phase == PH_READ) && mode_s && (byte_cnt != 2'd3);
  assign bit_idx   = IW'({byte_cnt, bit_cnt});

  tw_reply_tx #(.NBITS(REPLY_BITS), .IW(IW)) tx_i (
    .clk(clk),
    .rst(rst),
    .fall_evt(fall_evt),
    .active(tx_active),
    .bit_idx(bit_idx),
    .reply(reply),
    .dout(ser_data_out),
    .oe(ser_data_oe)
  );
endmodule

// File: rtl/tw_ctrl_slave_chk.sv
module tw_ctrl_slave_chk
  import tw_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       data_oe,
  input logic       data_out,
  input logic       enabled,
  input phase_t     phase,
  input logic       mode_s,
  input logic       fall_evt,
  input logic       mem_we,
  input logic [6:0] wr_ptr
);
  // R1: silent in the first cycle after reset
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!data_oe && !data_out));

  // R2: no drive before the enabling edge
  p_drive_needs_enable_r2: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> enabled);

  // R8: drive only in a read phase with mode high
  p_drive_only_read_r8: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> (phase == PH_READ && mode_s));

  // R10: reply bit moves only after a falling serial edge
  p_dout_on_fall_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_out) |-> $past(fall_evt));

  // R10: driver turns on only after a falling serial edge
  p_oe_on_fall_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(data_oe) |-> $past(fall_evt));

  // R6: memory is never written at an invalid address
  p_write_in_range_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ({1'b0, wr_ptr} < 8'(NUM_REGS)));
endmodule

bind tw_ctrl_slave tw_ctrl_slave_chk #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk(clk),
  .rst(rst),
  .data_oe(ser_data_oe),
  .data_out(ser_data_out),
  .enabled(enabled),
  .phase(phase),
  .mode_s(mode_s),
  .fall_evt(fall_evt),
  .mem_we(mem_we),
  .wr_ptr(wr_ptr)
);

// File: tb/tw_ctrl_slave_tb_top.sv
`timescale 1ns/1ps
module tw_ctrl_slave_tb_top;
  localparam logic [5:0] DEV  = 6'h2A;
  localparam logic [5:0] BAD  = 6'h15;
  localparam int         NREG = 16;
  localparam int         HALF = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_mode = 1'b1, ser_clk = 1'b1, ser_din = 1'b0;
  logic ser_dout, ser_oe;

  always #2 clk = ~clk;

  tw_ctrl_slave #(.DEV_ADDR(DEV), .NUM_REGS(NREG)) dut_i (
    .clk(clk), .rst(rst), .ser_mode(ser_mode), .ser_clk(ser_clk),
    .ser_data_in(ser_din), .ser_data_out(ser_dout), .ser_data_oe(ser_oe)
  );

  int n_chk = 0, n_fail = 0;
  logic [15:0] model [NREG];
  logic        written [NREG];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] echo_exp(input logic [6:0] r);
    return {(int'(r) >= NREG), r};
  endfunction

  function automatic logic [15:0] data_exp(input logic [6:0] r);
    if (int'(r) >= NREG) return 16'h0;
    return model[r[3:0]];
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic ser_bit(input logic b);
    ser_clk = 1'b0; ser_din = b; #HALF;
    ser_clk = 1'b1; #HALF;
  endtask

  task automatic send_byte(input logic m, input logic [7:0] v);
    if (ser_mode !== m) begin ser_mode = m; #HALF; end
    for (int i = 0; i < 8; i++) ser_bit(v[i]);
  endtask

  task automatic sel(input logic [5:0] dev, input logic [1:0] t);
    send_byte(1'b0, {dev, t});
  endtask

  task automatic do_write(input logic [5:0] dev, input logic [6:0] r, input logic [15:0] d);
    sel(dev, 2'b01);
    send_byte(1'b1, {1'b0, r});
    send_byte(1'b1, d[15:8]);
    send_byte(1'b1, d[7:0]);
    if (dev == DEV && int'(r) < NREG) begin
      model[r[3:0]] = d; written[r[3:0]] = 1'b1;
    end
  endtask

  task automatic do_prep(input logic [6:0] r);
    sel(DEV, 2'b01);
    send_byte(1'b1, {1'b1, r});
  endtask

  // clocks out 24 bits; returns data, count of driven bits, count of bits unstable across a rise
  task automatic recv(output logic [23:0] b, output int oe_cnt, output int moved);
    logic pre;
    oe_cnt = 0; moved = 0;
    if (ser_mode !== 1'b1) begin ser_mode = 1'b1; #HALF; end
    for (int i = 0; i < 24; i++) begin
      ser_clk = 1'b0; #(HALF-4);
      b[i] = ser_dout; pre = ser_dout;
      if (ser_oe === 1'b1) oe_cnt++;
      #4; ser_clk = 1'b1; #(HALF-4);
      if (ser_dout !== pre && i < 23) moved++;
      #4;
    end
  endtask

  task automatic read_chk(input logic [6:0] r, input string tag);
    logic [23:0] b; int oe_cnt, moved;
    do_prep(r);
    sel(DEV, 2'b11);
    recv(b, oe_cnt, moved);
    chk({tag, " echo"}, {24'h0, b[7:0]}, {24'h0, echo_exp(r)});
    chk({tag, " data"}, {16'h0, b[15:8], b[23:16]}, {16'h0, data_exp(r)});
    chk({tag, " R8 drive bits"}, oe_cnt, 24);
    chk({tag, " R10 stable across rise"}, moved, 0);
    #HALF;
    chk({tag, " R8 released"}, {31'h0, ser_oe}, 0);
  endtask

  task automatic no_reply(input string tag);
    logic [23:0] b; int oe_cnt, moved;
    recv(b, oe_cnt, moved);
    chk(tag, oe_cnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd4711);
    for (int i = 0; i < NREG; i++) begin model[i] = 16'h0; written[i] = 1'b0; end
    do_reset();
    #1;
    chk("R1 oe after reset", {31'h0, ser_oe}, 0);
    chk("R1 dout after reset", {31'h0, ser_dout}, 0);

    // R2: enabling pulse, then normal traffic
    ser_bit(1'b0);
    do_write(DEV, 7'd1, 16'hA5C3);
    read_chk(7'd1, "R3 R4 R5 first write");

    // R2: after reset, traffic without an enabling edge is lost; R1 contents kept
    do_reset();
    sel(DEV, 2'b01);
    send_byte(1'b1, {1'b0, 7'd1});
    send_byte(1'b1, 8'h12);
    send_byte(1'b1, 8'h34);
    read_chk(7'd1, "R2 R1 lost transfer");

    // R4: asymmetric value exposes bit order
    do_write(DEV, 7'd2, 16'h8001);
    read_chk(7'd2, "R4 bit order");

    // R7: foreign address write and read
    do_write(BAD, 7'd2, 16'hFFFF);
    read_chk(7'd2, "R7 foreign write");
    do_prep(7'd2);
    sel(BAD, 2'b11);
    no_reply("R7 foreign read drive");

    // R8: type-11 without an armed read
    sel(DEV, 2'b11);
    no_reply("R8 unarmed read drive");

    // R9: intervening select cancels arming
    do_prep(7'd2);
    do_write(DEV, 7'd3, 16'h0F0E);
    sel(DEV, 2'b11);
    no_reply("R9 cancelled read drive");
    read_chk(7'd3, "R9 intervening write");

    // R6: invalid addresses
    do_write(DEV, 7'd16, 16'hBEEF);
    read_chk(7'd16, "R6 boundary invalid");
    read_chk(7'h50, "R6 far invalid");
    do_write(DEV, 7'd15, 16'h7E81);
    read_chk(7'd15, "R6 last valid");

    // R11: trailing byte after the data bytes
    do_write(DEV, 7'd4, 16'h1357);
    send_byte(1'b1, 8'hFF);
    send_byte(1'b1, 8'h00);
    read_chk(7'd4, "R11 trailing bytes");

    // random mix of writes and reads
    for (int n = 0; n < 30; n++) begin
      logic [6:0]  r;
      logic [15:0] d;
      r = 7'($urandom % NREG);
      d = 16'($urandom);
      if ($urandom % 4 != 0) begin
        do_write(DEV, r, d);
      end else if (written[r[3:0]]) begin
        read_chk(r, "R3 R5 random read");
      end
    end
    for (int i = 0; i < NREG; i++) begin
      if (written[i]) read_chk(7'(i), "R3 R5 final sweep");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule